// File: doc/BRIEF.md
# Opcode Fetch Machine-Cycle Sequencer

This block runs the opcode-fetch machine cycle for a small 8-bit processor bus interface. A start request taken while idle begins a fetch. The block then steps through T-states on a free-running clock. In the first state it puts the program counter on the address outputs. The low byte goes out on a shared address/data bus, and the high byte goes out on a dedicated bus. A latch-enable pulse tells external logic to capture the low byte.

In the next two states the shared bus is released and the read strobe is held low. On the clock edge that closes the third state, the byte the memory returns is stored in the instruction register, and the program counter advances by one. The fourth state raises a decode-ready pulse. An extra-state count, sampled with the start request, appends up to two idle states for longer fetches. A one-cycle done pulse marks the last state of the fetch.

Top module: `opf_seq_top`

## Requirements
- R1: A synchronous active-high reset sets the program counter and instruction register to 0 and returns the sequencer to idle. In reset and idle: readN, writeN and intAckN are 1, addrLatch is 0, busOe is 0 and busy is 0.
- R2: A start seen high on a clock edge while idle makes the next cycle T1. In T1, addrLatch is 1, busOe is 1, busOut holds the program counter bits 7:0 and addrHigh holds bits 15:8. addrLatch is high in T1 only.
- R3: While busy, memIo is 0, stat1 and stat0 are both 1, writeN is 1 and intAckN is 1. When idle, stat1 and stat0 are both 0 and memIo is 0.
- R4: readN is 0 in T2 and T3 only, which is exactly the two cycles that follow the latch pulse.
- R5: busOe is 0 from T2 to the end of the fetch. addrHigh keeps the fetch address high byte through T1 to T3 and is 0 at every other time.
- R6: On the edge that ends T3, the instruction register loads busIn and the program counter increases by exactly one. Neither changes at any other time.
- R7: decodeReady is a one-cycle pulse in T4. In that cycle irOut already holds the newly fetched byte.
- R8: The value on extraStates when start is accepted adds that many idle states after T4. A value of 3 counts as 2. In these states readN is 1, addrLatch is 0 and busOe is 0. Later changes on extraStates have no effect on a running fetch.
- R9: done is high only in the final state of the fetch, so a fetch is busy for 4 + extra cycles. After that the sequencer is idle.
- R10: start asserted while a fetch is running is ignored: the sequence timing is unchanged and the program counter advances only once.
- R11: With the program counter at 2050H and memory returning 3EH, the fetch leaves irOut = 3EH and pcOut = 2051H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Fetch request, taken when idle |
| extraStates | input | 2 | Extra idle states after T4 (0 to 2, 3 counts as 2) |
| busIn | input | 8 | Byte read from the shared address/data bus |
| busOut | output | 8 | Low address byte driven onto the shared bus |
| busOe | output | 1 | Output enable for busOut |
| addrHigh | output | 8 | High address byte |
| addrLatch | output | 1 | Address latch enable, high in T1 |
| memIo | output | 1 | Memory/IO select, 0 means memory |
| stat1 | output | 1 | Status bit 1 |
| stat0 | output | 1 | Status bit 0 |
| readN | output | 1 | Active-low read strobe |
| writeN | output | 1 | Active-low write strobe, always inactive |
| intAckN | output | 1 | Active-low interrupt acknowledge, always inactive |
| irOut | output | 8 | Instruction register |
| pcOut | output | 16 | Program counter |
| decodeReady | output | 1 | One-cycle pulse in T4 |
| done | output | 1 | One-cycle pulse in the final state |
| busy | output | 1 | A fetch is in progress |

## Verification
The bench runs fetches with every extra-state value, including the saturating value 3, and changes extraStates after the start request. A design that sampled the count late or did not clamp it would give the wrong fetch length and misplace done. Start requests made in the middle of a fetch check that a re-trigger does not stretch or restart the cycle, and that it does not add a second increment. A read window shifted by one state, or a bus that stays enabled past T1, shows up in the per-cycle comparison. A design that captured the byte on the wrong edge would miss the per-address memory pattern, which includes the 2050H/3EH case.

// File: rtl/opf_pkg.sv
package opf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4,
    ST_XTRA = 3'd5
  } tState;

  // strobes from the control to the datapath
  typedef struct packed {
    logic drvLow;     // drive low address byte on shared bus
    logic holdHigh;   // present high address byte
    logic captureIr;  // load instruction register this edge
    logic bumpPc;     // advance program counter this edge
  } tStrobes;

endpackage

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
#(
  parameter int EXTRA_W   = 2,
  parameter int MAX_EXTRA = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [EXTRA_W-1:0] extraStates,
  output tStrobes            strb,
  output logic               addrLatch,
  output logic               memIo,
  output logic               stat1,
  output logic               stat0,
  output logic               readN,
  output logic               writeN,
  output logic               intAckN,
  output logic               decodeReady,
  output logic               done,
  output logic               busy
);

  localparam logic [EXTRA_W-1:0] MAX_X = EXTRA_W'(MAX_EXTRA);
  localparam logic [EXTRA_W-1:0] ONE_X = EXTRA_W'(1);

  tState             state, stateNext;
  logic [EXTRA_W-1:0] extraLeft, extraNext;
  logic [EXTRA_W-1:0] extraClamped;

  assign extraClamped = (extraStates > MAX_X) ? MAX_X : extraStates;

  always_comb begin
    stateNext = state;
    extraNext = extraLeft;
    case (state)
      ST_IDLE: if (start) begin
        stateNext = ST_T1;
        extraNext = extraClamped;
      end
      ST_T1: stateNext = ST_T2;
      ST_T2: stateNext = ST_T3;
      ST_T3: stateNext = ST_T4;
      ST_T4: stateNext = (extraLeft == '0) ? ST_IDLE : ST_XTRA;
      ST_XTRA: begin
        if (extraLeft == ONE_X) stateNext = ST_IDLE;
        extraNext = extraLeft - ONE_X;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      extraLeft <= '0;
    end else begin
      state     <= stateNext;
      extraLeft <= extraNext;
    end
  end

  assign busy          = (state != ST_IDLE);
  assign addrLatch     = (state == ST_T1);
  assign readN         = !((state == ST_T2) || (state == ST_T3));
  assign memIo         = 1'b0;
  assign stat1         = busy;
  assign stat0         = busy;
  assign writeN        = 1'b1;
  assign intAckN       = 1'b1;
  assign decodeReady   = (state == ST_T4);
  assign done          = ((state == ST_T4) && (extraLeft == '0)) ||
                         ((state == ST_XTRA) && (extraLeft == ONE_X));

  assign strb.drvLow    = (state == ST_T1);
  assign strb.holdHigh  = (state == ST_T1) || (state == ST_T2) || (state == ST_T3);
  assign strb.captureIr = (state == ST_T3);
  assign strb.bumpPc    = (state == ST_T3);

  assert_ale_single_R2: assert property (@(posedge clk) disable iff (rst)
    addrLatch |=> !addrLatch);

  assert_rd_after_ale_R4: assert property (@(posedge clk) disable iff (rst)
    addrLatch |=> !readN);

  assert_rd_two_cycles_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(readN) |=> !readN);

  assert_status_R3: assert property (@(posedge clk) disable iff (rst)
    !readN |-> (stat1 && stat0 && !memIo && writeN && intAckN));

  assert_decode_after_read_R7: assert property (@(posedge clk) disable iff (rst)
    decodeReady |-> $past(!readN));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

endmodule

// File: rtl/opf_datapath.sv
module opf_datapath
  import opf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  tStrobes           strb,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [ADDR_W-DATA_W-1:0] addrHigh,
  output logic [DATA_W-1:0] irOut,
  output logic [ADDR_W-1:0] pcOut
);

  localparam int HIGH_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] pcReg;
  logic [DATA_W-1:0] irReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg <= '0;
      irReg <= '0;
    end else begin
      if (strb.captureIr) irReg <= busIn;
      if (strb.bumpPc)    pcReg <= pcReg + ADDR_W'(1);
    end
  end

  assign busOe    = strb.drvLow;
  assign busOut   = strb.drvLow ? pcReg[DATA_W-1:0] : '0;
  assign addrHigh = strb.holdHigh ? pcReg[ADDR_W-1:DATA_W] : HIGH_W'(0);
  assign irOut    = irReg;
  assign pcOut    = pcReg;

  assert_pc_step_R6: assert property (@(posedge clk) disable iff (rst)
    strb.bumpPc |=> (pcOut == $past(pcOut) + ADDR_W'(1)));

  assert_pc_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !strb.bumpPc |=> $stable(pcOut));

  assert_ir_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !strb.captureIr |=> $stable(irOut));

  assert_oe_window_R5: assert property (@(posedge clk) disable iff (rst)
    busOe |-> strb.holdHigh);

endmodule

// File: rtl/opf_seq_top.sv
module opf_seq_top
  import opf_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int EXTRA_W   = 2,
  parameter int MAX_EXTRA = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [EXTRA_W-1:0]       extraStates,
  input  logic [DATA_W-1:0]        busIn,
  output logic [DATA_W-1:0]        busOut,
  output logic                     busOe,
  output logic [ADDR_W-DATA_W-1:0] addrHigh,
  output logic                     addrLatch,
  output logic                     memIo,
  output logic                     stat1,
  output logic                     stat0,
  output logic                     readN,
  output logic                     writeN,
  output logic                     intAckN,
  output logic [DATA_W-1:0]        irOut,
  output logic [ADDR_W-1:0]        pcOut,
  output logic                     decodeReady,
  output logic                     done,
  output logic                     busy
);

  tStrobes strb;

  opf_ctrl #(.EXTRA_W(EXTRA_W), .MAX_EXTRA(MAX_EXTRA)) uCtrl (
    .clk(clk), .rst(rst), .start(start), .extraStates(extraStates),
    .strb(strb), .addrLatch(addrLatch), .memIo(memIo), .stat1(stat1),
    .stat0(stat0), .readN(readN), .writeN(writeN), .intAckN(intAckN),
    .decodeReady(decodeReady), .done(done), .busy(busy)
  );

  opf_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rst(rst), .strb(strb), .busIn(busIn), .busOut(busOut),
    .busOe(busOe), .addrHigh(addrHigh), .irOut(irOut), .pcOut(pcOut)
  );

endmodule

// File: tb/tb_opf_seq_top.sv
`timescale 1ns/1ps
module tb_opf_seq_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] extraStates = 2'b00;
  logic [7:0] busIn;
  logic [7:0] busOut, addrHigh, irOut;
  logic busOe, addrLatch, memIo, stat1, stat0, readN, writeN, intAckN;
  logic [15:0] pcOut;
  logic decodeReady, done, busy;

  always #5 clk = ~clk;

  opf_seq_top dut (
    .clk(clk), .rst(rst), .start(start), .extraStates(extraStates),
    .busIn(busIn), .busOut(busOut), .busOe(busOe), .addrHigh(addrHigh),
    .addrLatch(addrLatch), .memIo(memIo), .stat1(stat1), .stat0(stat0),
    .readN(readN), .writeN(writeN), .intAckN(intAckN), .irOut(irOut),
    .pcOut(pcOut), .decodeReady(decodeReady), .done(done), .busy(busy)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit comparing = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // memory model: byte depends on the address latched by the latch pulse
  function automatic logic [7:0] memByte(input logic [15:0] a);
    if (a == 16'h2050) return 8'h3E;
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
  endfunction

  logic [15:0] latchedAddr = 16'h0;
  always @(negedge clk) if (addrLatch && busOe) latchedAddr = {addrHigh, busOut};
  assign busIn = (!readN) ? memByte(latchedAddr) : 8'hFF;

  // behavioural reference: 0 idle, 1..4 = T1..T4, 5.. = extra states
  int refSt = 0;
  int refEx = 0;
  int refLen = 0;
  logic [15:0] refPc = 16'h0;
  logic [7:0]  refIr = 8'h0;

  always @(posedge clk) begin
    if (rst) begin
      refSt = 0; refPc = 16'h0; refIr = 8'h0; refEx = 0;
    end else begin
      if (refSt == 0) begin
        if (start) begin
          refSt = 1;
          refEx = (extraStates > 2) ? 2 : int'(extraStates);
        end
      end else if (refSt == 3) begin
        refIr = memByte(refPc);
        refPc = refPc + 16'h1;
        refSt = 4;
      end else if (refSt < 4) begin
        refSt = refSt + 1;
      end else if (refSt < 4 + refEx) begin
        refSt = refSt + 1;
      end else begin
        refSt = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (comparing && !rst) begin
      bit isBusy;
      isBusy = (refSt != 0);
      check(busy == isBusy, "R9 busy", busy, isBusy);
      check(addrLatch == (refSt == 1), "R2 addrLatch", addrLatch, refSt == 1);
      check(busOe == (refSt == 1), "R5 busOe", busOe, refSt == 1);
      if (refSt == 1) check(busOut == refPc[7:0], "R2 busOut", busOut, refPc[7:0]);
      check(addrHigh == ((refSt >= 1 && refSt <= 3) ? refPc[15:8] : 8'h00),
            "R5 addrHigh", addrHigh, (refSt >= 1 && refSt <= 3) ? refPc[15:8] : 8'h00);
      check(readN == !(refSt == 2 || refSt == 3), "R4 readN", readN, !(refSt == 2 || refSt == 3));
      check(stat1 == isBusy && stat0 == isBusy && memIo == 1'b0, "R3 status",
            {memIo, stat1, stat0}, {1'b0, isBusy, isBusy});
      check(writeN && intAckN, "R3 writeN/intAckN", {writeN, intAckN}, 2'b11);
      check(decodeReady == (refSt == 4), "R7 decodeReady", decodeReady, refSt == 4);
      check(done == (isBusy && refSt == 4 + refEx), "R9 done", done, isBusy && refSt == 4 + refEx);
      check(irOut == refIr, "R6 irOut", irOut, refIr);
      check(pcOut == refPc, "R6 pcOut", pcOut, refPc);
      if (refSt >= 5) check(readN && !addrLatch && !busOe, "R8 extra idle", {readN, addrLatch, busOe}, 3'b100);
    end
  end

  // one fetch: start pulse, then scramble extraStates, optional re-trigger
  task automatic runFetch(input logic [1:0] ex, input bit poke);
    int cyc;
    logic [15:0] pcBefore;
    int expLen;
    pcBefore = pcOut;
    expLen = 4 + ((ex > 2) ? 2 : int'(ex));
    @(negedge clk); start = 1'b1; extraStates = ex;
    @(negedge clk); start = 1'b0; extraStates = ~ex;
    cyc = 0;
    while (busy) begin
      cyc++;
      if (poke && cyc == 2) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    if (poke) begin
      check(cyc == expLen, "R10 length with re-trigger", cyc, expLen);
      check(pcOut == pcBefore + 16'h1, "R10 single increment", pcOut, pcBefore + 16'h1);
    end else begin
      check(cyc == expLen, "R9 R8 fetch length", cyc, expLen);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pcOut == 16'h0 && irOut == 8'h0, "R1 reset regs", {pcOut, irOut}, 24'h0);
    check(readN && writeN && intAckN && !addrLatch && !busOe && !busy, "R1 reset strobes",
          {readN, writeN, intAckN, addrLatch, busOe, busy}, 6'b111000);
    rst = 1'b0;
    comparing = 1;
    @(negedge clk);
    check(!busy && !stat1 && !stat0, "R3 idle status", {busy, stat1, stat0}, 3'b000);
    runFetch(2'd0, 0);
    runFetch(2'd1, 0);
    runFetch(2'd2, 0);
    runFetch(2'd3, 0);
    runFetch(2'd0, 1);
    runFetch(2'd2, 1);
    for (int i = 0; pcOut != 16'h2050; i++) runFetch(2'(i % 4), 0);
    runFetch(2'd1, 0);
    check(irOut == 8'h3E, "R11 ir at 2050H", irOut, 8'h3E);
    check(pcOut == 16'h2051, "R11 pc after 2050H", pcOut, 16'h2051);
    @(negedge clk); rst = 1'b1; comparing = 0;
    @(negedge clk);
    check(pcOut == 16'h0 && !busy && readN, "R1 reset after run", {pcOut, busy, readN}, {16'h0, 2'b01});
    finishRun();
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

endmodule